// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block guards a processor against runaway code. A counter advances once for each pulse on a slow tick input, and software must service the watchdog by writing an 8-bit service word. The write counts only if it carries a fixed 5-bit key and arrives inside a window. The window opens a fixed number of ticks after the last restart and closes at one of four upper limits. The upper limit is chosen by two bits of the same service word.

Three events raise a fault: a write that arrives too early, a write with the wrong key, and a window that closes with no service. An early write usually means a tight loop that contains the service write. Each fault pulses the error output for one clock. A valid service restarts the count and latches the new window select and a clock-monitor select bit. The clock-monitor bit is only stored and brought out.

Top module: `keyed_wdog`

## Requirements
- R1: The tick counter advances only on clock edges where `tick_i` is 1. With `tick_i` held at 0, no expiry fault occurs however many clocks pass.
- R2: The service word is decoded as follows: bits 7:6 are the window select, bits 5:1 are the key, and bit 0 is the clock-monitor select. An accepted service drives the written window select onto `win_sel_o` and bit 0 onto `clkmon_o` after the same edge.
- R3: A write whose key field is not binary 01100 is a fault. It leaves `win_sel_o`, `clkmon_o` and the tick count unchanged.
- R4: Once a service has been accepted since reset, a write that has the correct key but arrives when fewer than `LOWER_TICKS` (default 2048) ticks have passed since the last restart is a fault. It latches nothing and does not restart the count.
- R5: The upper limit is `UPPER_BASE << sel`, which gives 8192, 16384, 32768 and 65536 ticks for select values 00, 01, 10 and 11. The tick that brings the count to the limit with no service is a fault, and it restarts the count at zero.
- R6: An accepted service (correct key, inside the window) raises no fault and restarts the count at zero. The next expiry is measured from there, using the newly written select.
- R7: After reset `err_o` is 0, `win_sel_o` is 11, `clkmon_o` is 0 and the count is zero. Before the first accepted service, the lower limit is not enforced.
- R8: `err_o` is a registered pulse. It goes high on the clock edge that samples the fault and low on the next edge, unless another fault is sampled there.
- R9: When an accepted service falls in the same cycle as the tick that would expire the window, the service wins: no fault is raised and the count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Idle-timer tick enable, one count per high cycle |
| wr_i | input | 1 | Service write strobe |
| wdata_i | input | 8 | Service word: select[7:6], key[5:1], clock-monitor select[0] |
| err_o | output | 1 | Watchdog fault pulse |
| win_sel_o | output | 2 | Window select currently in force |
| clkmon_o | output | 1 | Stored clock-monitor select bit |

## Verification
The service write and the window-expiring tick can land in the same cycle. The bench provokes this by counting the window to one tick short of its limit and then issuing a correct-key write together with a tick. It expects no error pulse and the new select on the output. It then runs exactly one window of the new length and expects the expiry on the final tick, which shows that the count was restarted rather than allowed to run out.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned KEY_W = 5;
  localparam logic [KEY_W-1:0] SVC_KEY = 5'b01100;

  typedef struct packed {
    logic [1:0]       sel;
    logic [KEY_W-1:0] key;
    logic             clkmon;
  } svc_word_t;
endpackage

// File: rtl/wdog_tick_cnt.sv
module wdog_tick_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/wdog_svc_decode.sv
module wdog_svc_decode
  import wdog_pkg::*;
(
  input  logic [7:0] wdata_i,
  output logic       key_ok_o,
  output logic [1:0] sel_o,
  output logic       clkmon_o
);
  svc_word_t word;

  assign word     = svc_word_t'(wdata_i);
  assign key_ok_o = (word.key == SVC_KEY);
  assign sel_o    = word.sel;
  assign clkmon_o = word.clkmon;
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int unsigned LOWER_TICKS = 2048,
  parameter int unsigned UPPER_BASE  = 8192,
  parameter int unsigned CNT_W       = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       sel_i,
  input  logic             armed_i,
  input  logic             tick_i,
  output logic             early_o,
  output logic             last_tick_o,
  output logic [CNT_W-1:0] lim_m1_o
);
  localparam logic [CNT_W-1:0] LOWER_C = CNT_W'(LOWER_TICKS);

  logic [CNT_W-1:0] lim_m1 [4];

  // one limit per select value, each double the previous
  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_m1[g] = CNT_W'((UPPER_BASE << g) - 1);
  end

  assign lim_m1_o    = lim_m1[sel_i];
  assign early_o     = armed_i && (cnt_i < LOWER_C);
  assign last_tick_o = tick_i && (cnt_i == lim_m1_o);
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned LOWER_TICKS = 2048,
  parameter int unsigned UPPER_BASE  = 8192
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       err_o,
  output logic [1:0] win_sel_o,
  output logic       clkmon_o
);
  localparam int unsigned CNT_W = $clog2(UPPER_BASE * 8);

  logic [CNT_W-1:0] cnt, lim_m1;
  logic             key_ok, wr_clkmon, early, last_tick;
  logic [1:0]       wr_sel;
  logic             svc_ok, fault, restart;
  logic             err_q, clkmon_q, armed_q;
  logic [1:0]       sel_q;

  wdog_svc_decode u_dec (
    .wdata_i (wdata_i),
    .key_ok_o(key_ok),
    .sel_o   (wr_sel),
    .clkmon_o(wr_clkmon)
  );

  wdog_window #(
    .LOWER_TICKS(LOWER_TICKS),
    .UPPER_BASE (UPPER_BASE),
    .CNT_W      (CNT_W)
  ) u_win (
    .cnt_i      (cnt),
    .sel_i      (sel_q),
    .armed_i    (armed_q),
    .tick_i     (tick_i),
    .early_o    (early),
    .last_tick_o(last_tick),
    .lim_m1_o   (lim_m1)
  );

  wdog_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (restart),
    .cnt_o (cnt)
  );

  assign svc_ok  = wr_i && key_ok && !early;
  // a good service beats an expiring tick in the same cycle
  assign fault   = (wr_i && !svc_ok) || (last_tick && !svc_ok);
  assign restart = svc_ok || last_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= 1'b0;
      sel_q    <= 2'b11;
      clkmon_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      err_q <= fault;
      if (svc_ok) begin
        sel_q    <= wr_sel;
        clkmon_q <= wr_clkmon;
        armed_q  <= 1'b1;
      end
    end
  end

  assign err_o     = err_q;
  assign win_sel_o = sel_q;
  assign clkmon_o  = clkmon_q;

  AST_BAD_KEY_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (wdata_i[5:1] != SVC_KEY)) |=> err_o); // R3
  AST_EARLY_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && armed_q && (cnt < CNT_W'(LOWER_TICKS))) |=> err_o); // R4
  AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= lim_m1); // R5
  AST_SEL_HOLD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(win_sel_o)); // R2
  AST_FAULT_NO_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(win_sel_o) && $stable(clkmon_o))); // R3
endmodule

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;
  localparam int unsigned LOW  = 16;
  localparam int unsigned BASE = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       err;
  logic [1:0] win_sel;
  logic       clkmon;

  int n_chk = 0;
  int n_bad = 0;

  keyed_wdog #(.LOWER_TICKS(LOW), .UPPER_BASE(BASE)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .wr_i     (wr),
    .wdata_i  (wdata),
    .err_o    (err),
    .win_sel_o(win_sel),
    .clkmon_o (clkmon)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] good(input logic [1:0] s, input logic c);
    return {s, 5'b01100, c};
  endfunction
  function automatic logic [7:0] badk(input logic [1:0] s, input logic c);
    return {s, 5'b10101, c};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, one clock edge, return at next negedge
  task automatic step(input logic t, input logic w, input logic [7:0] d);
    tick = t; wr = w; wdata = d;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr = 1'b0;
  endtask

  // n tick cycles, returns number of cycles with err high
  task automatic ticks(input int n, output int errs);
    errs = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 8'h00);
      if (err) errs++;
    end
  endtask

  task automatic t_reset;
    check("R7 err after reset", err, 0);
    check("R7 sel after reset", win_sel, 3);
    check("R7 clkmon after reset", clkmon, 0);
  endtask

  task automatic t_first_early;
    int e;
    ticks(5, e);
    step(1'b0, 1'b1, good(2'b00, 1'b1));
    check("R7 first service early accepted", err, 0);
    check("R2 sel latched", win_sel, 0);
    check("R2 clkmon latched", clkmon, 1);
  endtask

  task automatic t_lower_edge;
    int e;
    ticks(LOW - 1, e);
    step(1'b0, 1'b1, good(2'b10, 1'b0));
    check("R4 write one tick early faults", err, 1);
    check("R4 early write latches nothing", win_sel, 0);
    step(1'b0, 1'b0, 8'h00);
    check("R8 err drops after one clock", err, 0);
    ticks(1, e);
    step(1'b0, 1'b1, good(2'b10, 1'b0));
    check("R4 write at lower limit accepted", err, 0);
    check("R2 sel after boundary service", win_sel, 2);
    check("R2 clkmon after boundary service", clkmon, 0);
  endtask

  task automatic t_bad_key;
    int e;
    ticks(20, e);
    step(1'b0, 1'b1, badk(2'b01, 1'b1));
    check("R3 wrong key faults", err, 1);
    check("R3 wrong key keeps sel", win_sel, 2);
    check("R3 wrong key keeps clkmon", clkmon, 0);
    step(1'b0, 1'b0, 8'h00);
    check("R8 err single pulse", err, 0);
  endtask

  task automatic t_expiry;
    int e;
    step(1'b0, 1'b1, good(2'b01, 1'b1));
    check("R6 in-window service no fault", err, 0);
    ticks(2 * BASE - 1, e);
    check("R5 no fault before limit sel=01", e, 0);
    ticks(1, e);
    check("R5 fault at limit sel=01", e, 1);
    step(1'b0, 1'b0, 8'h00);
    check("R8 expiry pulse one clock", err, 0);
    ticks(3, e);
    step(1'b0, 1'b1, good(2'b01, 1'b1));
    check("R5 count restarted after expiry, early write faults", err, 1);
  endtask

  task automatic t_tick_gate;
    int e, hits;
    hits = 0;
    for (int i = 0; i < 600; i++) begin
      step(1'b0, 1'b0, 8'h00);
      if (err) hits++;
    end
    check("R1 no expiry without ticks", hits, 0);
    ticks(2 * BASE - 4, e);
    check("R1 count held while idle", e, 0);
    ticks(1, e);
    check("R1 expiry after remaining ticks", e, 1);
  endtask

  task automatic t_collision;
    int e;
    ticks(2 * BASE - 1, e);
    check("R9 no fault before collision", e, 0);
    step(1'b1, 1'b1, good(2'b00, 1'b0));
    check("R9 service wins over expiring tick", err, 0);
    check("R9 sel latched on collision", win_sel, 0);
    ticks(BASE - 1, e);
    check("R6 new window not expired early", e, 0);
    ticks(1, e);
    check("R6 new window sel=00 expires at base", e, 1);
  endtask

  task automatic t_max_sel;
    int e;
    ticks(20, e);
    step(1'b0, 1'b1, good(2'b11, 1'b1));
    check("R2 sel=11 latched", win_sel, 3);
    ticks(8 * BASE - 1, e);
    check("R5 no fault before limit sel=11", e, 0);
    ticks(1, e);
    check("R5 fault at limit sel=11", e, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_early();
    t_lower_edge();
    t_bad_key();
    t_expiry();
    t_tick_gate();
    t_collision();
    t_max_sel();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule